// File: doc/BRIEF.md
# Multiplexed Asynchronous DRAM Controller

This block sits between a synchronous host and a 4M x 1 asynchronous dynamic RAM whose address pins are shared between row and column. A host request carries one data bit and a 22-bit cell address. The controller splits the address into an upper row half and a lower column half. It places the row on the shared bus under a falling row strobe, then the column under a falling column strobe, and drives the write-enable and data pins for an early-write cycle or samples the returned bit for a read.

All analog timing limits enter as nanosecond parameters. They are converted to clock-cycle counts, rounded up, at the configured clock period. Refresh uses the column-before-row method, so the memory's internal row counter supplies the row and the controller has no refresh address of its own. After reset the controller stays closed to traffic for a power-up pause followed by eight refresh cycles. In normal operation it issues one refresh per refresh interval. A pending refresh beats a new request at an idle point, but a cycle that has begun always completes.

Read data is captured at the clock edge on which the column strobe is raised, and is returned with a single-cycle valid pulse.

Top module: `adram_ctrl`

## Requirements
- R1: During a user cycle the bus carries `req_addr[21:11]` when the row strobe falls and `req_addr[10:0]` when the column strobe falls.
- R2: `req_ready` stays low after reset until at least the power-up pause (in cycles) has elapsed and exactly eight column-before-row refreshes have been issued.
- R3: In a refresh, the column strobe is low for at least one cycle before the row strobe falls, and both stay low together for max(tRAS, tCHR) cycles.
- R4: After initialisation, one refresh is issued per refresh interval, so an idle window of ten intervals holds ten refreshes, plus or minus one.
- R5: A write is an early write. Write-enable (active low) is already low and stable when the column strobe falls, and `req_wdata` is on the data pin at that fall.
- R6: A read raises `rd_valid` for exactly one cycle, 3 + max(tCAS, tRAS - tRCD) cycles after the accepting edge, with the stored bit on `rd_data`. A write produces no `rd_valid` pulse.
- R7: Every row-strobe low period lasts at least tRAS cycles, and every high period before a fall lasts at least tRP cycles.
- R8: In a user cycle the column strobe falls max(ceil(tRCD), tRAH+1) cycles after the row strobe, and never later than the floor of the tRCD maximum.
- R9: A pending refresh holds `req_ready` low, refreshes keep their rate under continuous traffic, and no user cycle is cut short: each user row-strobe low period is exactly tRCD + column-hold cycles.
- R10: In reset, all three strobes are high, `rd_valid` is 0 and `req_ready` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Request accepted on this edge when valid |
| req_we | input | 1 | 1 = write, 0 = read |
| req_addr | input | 22 | Cell address, row half in the upper bits |
| req_wdata | input | 1 | Bit to write |
| rd_valid | output | 1 | One-cycle read-return pulse |
| rd_data | output | 1 | Bit read |
| dram_ras_n | output | 1 | Row strobe, active low |
| dram_cas_n | output | 1 | Column strobe, active low |
| dram_we_n | output | 1 | Write enable, active low |
| dram_addr | output | 11 | Shared row/column address bus |
| dram_din | output | 1 | Data to memory |
| dram_dout | input | 1 | Data from memory |

## Verification
A read result is due nine cycles after the accepting edge with the bench configuration: three cycles to reach the column phase and six cycles of column hold. The bench counts falling clock edges from acceptance to `rd_valid` and requires exactly that count. It then checks that the pulse has gone on the next falling edge. Strobe checks run in a monitor that samples on falling edges, mid-cycle. The monitor derives the row-to-column delay, low and high widths and refresh ordering from the number of falling edges between transitions. Write checks wait the read latency plus two cycles, so a stray pulse would be seen.

// File: rtl/adram_pkg.sv
package adram_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_ROW,     // row on bus, strobes high (address set-up)
        ST_RAS,     // row strobe low, row held
        ST_COL,     // column on bus, column strobe still high
        ST_CAS,     // both strobes low, access or write
        ST_PRE,     // precharge, both strobes high
        ST_RCAS,    // refresh: column strobe leads
        ST_RREF     // refresh: both strobes low
    } seq_state_e;

    typedef struct packed {
        logic ras_n;
        logic cas_n;
        logic we_n;
    } strobe_t;

    function automatic int unsigned ns_to_cyc(input int unsigned ns,
                                              input int unsigned period_ps);
        return (ns * 1000 + period_ps - 1) / period_ps;
    endfunction

    function automatic int unsigned ns_floor_cyc(input int unsigned ns,
                                                 input int unsigned period_ps);
        return (ns * 1000) / period_ps;
    endfunction

    function automatic int unsigned max2(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

    function automatic strobe_t strobes_for(input seq_state_e st, input logic is_wr);
        strobe_t s;
        s = '{ras_n: 1'b1, cas_n: 1'b1, we_n: 1'b1};
        case (st)
            ST_ROW:  s = '{ras_n: 1'b1, cas_n: 1'b1, we_n: !is_wr};
            ST_RAS:  s = '{ras_n: 1'b0, cas_n: 1'b1, we_n: !is_wr};
            ST_COL:  s = '{ras_n: 1'b0, cas_n: 1'b1, we_n: !is_wr};
            ST_CAS:  s = '{ras_n: 1'b0, cas_n: 1'b0, we_n: !is_wr};
            ST_RCAS: s = '{ras_n: 1'b1, cas_n: 1'b0, we_n: 1'b1};
            ST_RREF: s = '{ras_n: 1'b0, cas_n: 1'b0, we_n: 1'b1};
            default: s = '{ras_n: 1'b1, cas_n: 1'b1, we_n: 1'b1};
        endcase
        return s;
    endfunction

endpackage

// File: rtl/adram_delay.sv
module adram_delay #(
    parameter int unsigned W = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         zero
);
    logic [W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst)
            cnt_q <= '0;
        else if (load)
            cnt_q <= load_val;
        else if (cnt_q != '0)
            cnt_q <= cnt_q - 1'b1;
    end

    assign zero = (cnt_q == '0);

endmodule

// File: rtl/adram_refresh_sched.sv
module adram_refresh_sched #(
    parameter int unsigned PWRUP_CYC = 20000,
    parameter int unsigned INT_CYC   = 1560,
    parameter int unsigned INIT_REFS = 8
) (
    input  logic clk,
    input  logic rst,
    input  logic ack,
    output logic req,
    output logic init_done
);
    localparam int unsigned PW = $clog2(PWRUP_CYC + 1);
    localparam int unsigned IW = $clog2(INT_CYC + 1);
    localparam int unsigned NW = $clog2(INIT_REFS + 1);

    logic [PW-1:0] pause_q;
    logic [NW-1:0] left_q;
    logic [IW-1:0] int_q;
    logic          due_q;
    logic          pause_done;
    logic          wrap;

    assign pause_done = (pause_q == '0);
    assign init_done  = pause_done && (left_q == '0);
    assign wrap       = init_done && (int_q == IW'(INT_CYC - 1));

    always_ff @(posedge clk) begin
        if (rst)
            pause_q <= PW'(PWRUP_CYC);
        else if (!pause_done)
            pause_q <= pause_q - 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst)
            left_q <= NW'(INIT_REFS);
        else if (ack && pause_done && left_q != '0)
            left_q <= left_q - 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst || !init_done)
            int_q <= '0;
        else if (wrap)
            int_q <= '0;
        else
            int_q <= int_q + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst)
            due_q <= 1'b0;
        else if (wrap)
            due_q <= 1'b1;
        else if (ack && init_done)
            due_q <= 1'b0;
    end

    assign req = (pause_done && left_q != '0) || due_q;

    // R2: no refresh is granted while the power-up pause runs
    p_no_early_refresh_r2: assert property (@(posedge clk) disable iff (rst)
        ack |-> pause_done);

    // R4: a due refresh stays pending until it is granted
    p_due_kept_r4: assert property (@(posedge clk) disable iff (rst)
        (due_q && !ack) |=> due_q);

endmodule

// File: rtl/adram_seq.sv
module adram_seq
    import adram_pkg::*;
#(
    parameter int unsigned AW       = 11,
    parameter int unsigned D_RAS    = 1,
    parameter int unsigned D_COL    = 1,
    parameter int unsigned D_CAS    = 6,
    parameter int unsigned D_PRE    = 6,
    parameter int unsigned D_RCAS   = 1,
    parameter int unsigned D_RREF   = 8,
    parameter int unsigned RAS_MIN  = 8,
    parameter int unsigned RP_MIN   = 6,
    parameter int unsigned RCD_MIN  = 2,
    parameter int unsigned RCD_MAX  = 6
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            init_done,
    input  logic            ref_req,
    output logic            ref_ack,
    input  logic            req_valid,
    output logic            req_ready,
    input  logic            req_we,
    input  logic [2*AW-1:0] req_addr,
    input  logic            req_wdata,
    output logic            rd_valid,
    output logic            rd_data,
    output logic            dram_ras_n,
    output logic            dram_cas_n,
    output logic            dram_we_n,
    output logic [AW-1:0]   dram_addr,
    output logic            dram_din,
    input  logic            dram_dout
);
    localparam int unsigned DMAX  = max2(max2(max2(D_RAS, D_COL), max2(D_CAS, D_PRE)),
                                         max2(D_RCAS, D_RREF));
    localparam int unsigned TW    = $clog2(DMAX + 1);
    localparam int unsigned RUN_W = $clog2(RAS_MIN + RP_MIN + RCD_MAX + DMAX + 4) + 1;
    localparam logic [RUN_W-1:0] RUN_SAT = '1;

    seq_state_e    st_q, st_d;
    logic          wr_q, wd_q;
    logic [AW-1:0] row_q, col_q;
    logic          wr_n, wd_n;
    logic [AW-1:0] row_n, col_n;
    logic          accept;
    logic          t_zero;
    logic [TW-1:0] dur_m1;
    logic          capture;
    strobe_t       stb_n;

    assign req_ready = (st_q == ST_IDLE) && init_done && !ref_req;
    assign ref_ack   = (st_q == ST_IDLE) && ref_req;
    assign accept    = req_ready && req_valid;

    always_comb begin
        st_d = st_q;
        case (st_q)
            ST_IDLE: begin
                if (ref_req)     st_d = ST_RCAS;
                else if (accept) st_d = ST_ROW;
            end
            ST_ROW:  if (t_zero) st_d = ST_RAS;
            ST_RAS:  if (t_zero) st_d = ST_COL;
            ST_COL:  if (t_zero) st_d = ST_CAS;
            ST_CAS:  if (t_zero) st_d = ST_PRE;
            ST_PRE:  if (t_zero) st_d = ST_IDLE;
            ST_RCAS: if (t_zero) st_d = ST_RREF;
            ST_RREF: if (t_zero) st_d = ST_PRE;
            default: st_d = ST_IDLE;
        endcase
    end

    always_comb begin
        case (st_d)
            ST_RAS:  dur_m1 = TW'(D_RAS - 1);
            ST_COL:  dur_m1 = TW'(D_COL - 1);
            ST_CAS:  dur_m1 = TW'(D_CAS - 1);
            ST_PRE:  dur_m1 = TW'(D_PRE - 1);
            ST_RCAS: dur_m1 = TW'(D_RCAS - 1);
            ST_RREF: dur_m1 = TW'(D_RREF - 1);
            default: dur_m1 = '0;
        endcase
    end

    adram_delay #(.W(TW)) u_timer (
        .clk      (clk),
        .rst      (rst),
        .load     (st_d != st_q),
        .load_val (dur_m1),
        .zero     (t_zero)
    );

    assign wr_n  = accept ? req_we                : wr_q;
    assign wd_n  = accept ? req_wdata             : wd_q;
    assign row_n = accept ? req_addr[2*AW-1:AW]   : row_q;
    assign col_n = accept ? req_addr[AW-1:0]      : col_q;
    assign stb_n = strobes_for(st_d, wr_n);

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q  <= ST_IDLE;
            wr_q  <= 1'b0;
            wd_q  <= 1'b0;
            row_q <= '0;
            col_q <= '0;
        end else begin
            st_q  <= st_d;
            wr_q  <= wr_n;
            wd_q  <= wd_n;
            row_q <= row_n;
            col_q <= col_n;
        end
    end

    // pins are registered from the next-state decode so they are glitch free
    always_ff @(posedge clk) begin
        if (rst) begin
            dram_ras_n <= 1'b1;
            dram_cas_n <= 1'b1;
            dram_we_n  <= 1'b1;
            dram_addr  <= '0;
            dram_din   <= 1'b0;
        end else begin
            dram_ras_n <= stb_n.ras_n;
            dram_cas_n <= stb_n.cas_n;
            dram_we_n  <= stb_n.we_n;
            dram_addr  <= (st_d == ST_COL || st_d == ST_CAS) ? col_n : row_n;
            dram_din   <= wd_n;
        end
    end

    assign capture = (st_q == ST_CAS) && t_zero && !wr_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_valid <= 1'b0;
            rd_data  <= 1'b0;
        end else begin
            rd_valid <= capture;
            if (capture)
                rd_data <= dram_dout;
        end
    end

    // checker counters: consecutive cycles of the row strobe low / high
    logic [RUN_W-1:0] low_run, high_run;

    always_ff @(posedge clk) begin
        if (rst) begin
            low_run  <= '0;
            high_run <= RUN_SAT;
        end else begin
            low_run  <= (!dram_ras_n && low_run != RUN_SAT) ? low_run + 1'b1
                      : (!dram_ras_n ? low_run : '0);
            high_run <= (dram_ras_n && high_run != RUN_SAT) ? high_run + 1'b1
                      : (dram_ras_n ? high_run : '0);
        end
    end

    // R7: row strobe low width and precharge width
    p_ras_low_min_r7: assert property (@(posedge clk) disable iff (rst)
        $rose(dram_ras_n) |-> (low_run >= RUN_W'(RAS_MIN)));
    p_ras_pre_min_r7: assert property (@(posedge clk) disable iff (rst)
        $fell(dram_ras_n) |-> (high_run >= RUN_W'(RP_MIN)));

    // R8: row-to-column strobe delay window in a user cycle
    p_rcd_window_r8: assert property (@(posedge clk) disable iff (rst)
        ($fell(dram_cas_n) && !dram_ras_n) |->
            (low_run >= RUN_W'(RCD_MIN) && low_run <= RUN_W'(RCD_MAX)));

    // R3: in a refresh the column strobe was already low before the row strobe fell
    p_cbr_order_r3: assert property (@(posedge clk) disable iff (rst)
        ($fell(dram_ras_n) && !dram_cas_n) |-> ($past(dram_cas_n) == 1'b0));

    // R5: write enable settled before the column strobe falls
    p_early_we_r5: assert property (@(posedge clk) disable iff (rst)
        ($fell(dram_cas_n) && !dram_ras_n) |-> $stable(dram_we_n));

    // R6: the read return is a single-cycle pulse
    p_rd_pulse_r6: assert property (@(posedge clk) disable iff (rst)
        rd_valid |=> !rd_valid);

    // R9: column strobe never rises while the row strobe stays low in a user cycle
    p_no_cut_r9: assert property (@(posedge clk) disable iff (rst)
        (!dram_ras_n && $rose(dram_cas_n)) |-> 1'b0);

endmodule

// File: rtl/adram_ctrl.sv
module adram_ctrl
    import adram_pkg::*;
#(
    parameter int unsigned DRAM_AW       = 11,
    parameter int unsigned CLK_PS        = 10000,
    parameter int unsigned T_RAS_NS      = 80,
    parameter int unsigned T_RP_NS       = 60,
    parameter int unsigned T_RCD_NS      = 20,
    parameter int unsigned T_RCD_MAX_NS  = 60,
    parameter int unsigned T_RAH_NS      = 10,
    parameter int unsigned T_CAS_NS      = 20,
    parameter int unsigned T_CSR_NS      = 5,
    parameter int unsigned T_CHR_NS      = 15,
    parameter int unsigned PWRUP_NS      = 200000,
    parameter int unsigned REF_INT_NS    = 15600,
    parameter int unsigned INIT_REFS     = 8
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 req_valid,
    output logic                 req_ready,
    input  logic                 req_we,
    input  logic [2*DRAM_AW-1:0] req_addr,
    input  logic                 req_wdata,
    output logic                 rd_valid,
    output logic                 rd_data,
    output logic                 dram_ras_n,
    output logic                 dram_cas_n,
    output logic                 dram_we_n,
    output logic [DRAM_AW-1:0]   dram_addr,
    output logic                 dram_din,
    input  logic                 dram_dout
);
    localparam int unsigned C_RAS     = max2(ns_to_cyc(T_RAS_NS, CLK_PS), 1);
    localparam int unsigned C_RP      = max2(ns_to_cyc(T_RP_NS, CLK_PS), 1);
    localparam int unsigned C_RAH     = max2(ns_to_cyc(T_RAH_NS, CLK_PS), 1);
    localparam int unsigned C_RCD     = max2(ns_to_cyc(T_RCD_NS, CLK_PS), C_RAH + 1);
    localparam int unsigned C_RCD_MAX = ns_floor_cyc(T_RCD_MAX_NS, CLK_PS);
    localparam int unsigned C_CAS     = max2(ns_to_cyc(T_CAS_NS, CLK_PS), 1);
    localparam int unsigned C_CSR     = max2(ns_to_cyc(T_CSR_NS, CLK_PS), 1);
    localparam int unsigned C_CHR     = ns_to_cyc(T_CHR_NS, CLK_PS);
    localparam int unsigned C_HOLD    = max2(C_CAS, (C_RAS > C_RCD) ? C_RAS - C_RCD : 1);
    localparam int unsigned C_RREF    = max2(C_RAS, C_CHR);
    localparam int unsigned C_PWRUP   = max2(ns_to_cyc(PWRUP_NS, CLK_PS), 1);
    localparam int unsigned C_REF_INT = max2(ns_to_cyc(REF_INT_NS, CLK_PS), C_RREF + C_RP + 2);

    logic ref_req, ref_ack, init_done;

    adram_refresh_sched #(
        .PWRUP_CYC (C_PWRUP),
        .INT_CYC   (C_REF_INT),
        .INIT_REFS (INIT_REFS)
    ) u_sched (
        .clk       (clk),
        .rst       (rst),
        .ack       (ref_ack),
        .req       (ref_req),
        .init_done (init_done)
    );

    adram_seq #(
        .AW      (DRAM_AW),
        .D_RAS   (C_RAH),
        .D_COL   (C_RCD - C_RAH),
        .D_CAS   (C_HOLD),
        .D_PRE   (C_RP),
        .D_RCAS  (C_CSR),
        .D_RREF  (C_RREF),
        .RAS_MIN (C_RAS),
        .RP_MIN  (C_RP),
        .RCD_MIN (C_RCD),
        .RCD_MAX (C_RCD_MAX)
    ) u_seq (
        .clk        (clk),
        .rst        (rst),
        .init_done  (init_done),
        .ref_req    (ref_req),
        .ref_ack    (ref_ack),
        .req_valid  (req_valid),
        .req_ready  (req_ready),
        .req_we     (req_we),
        .req_addr   (req_addr),
        .req_wdata  (req_wdata),
        .rd_valid   (rd_valid),
        .rd_data    (rd_data),
        .dram_ras_n (dram_ras_n),
        .dram_cas_n (dram_cas_n),
        .dram_we_n  (dram_we_n),
        .dram_addr  (dram_addr),
        .dram_din   (dram_din),
        .dram_dout  (dram_dout)
    );

    // checker counters for the start-up gate
    localparam int unsigned SW = $clog2(C_PWRUP + 1) + 1;
    localparam int unsigned GW = $clog2(INIT_REFS + 1);
    logic [SW-1:0] since_rst;
    logic [GW-1:0] grants;

    always_ff @(posedge clk) begin
        if (rst) begin
            since_rst <= '0;
            grants    <= '0;
        end else begin
            if (since_rst != SW'(C_PWRUP)) since_rst <= since_rst + 1'b1;
            if (ref_ack && grants != GW'(INIT_REFS)) grants <= grants + 1'b1;
        end
    end

    // R2: no host request is taken before the pause and the start-up refreshes
    p_ready_gated_r2: assert property (@(posedge clk) disable iff (rst)
        req_ready |-> (since_rst == SW'(C_PWRUP) && grants == GW'(INIT_REFS)));

    // R9: a pending refresh closes the host handshake
    p_refresh_first_r9: assert property (@(posedge clk) disable iff (rst)
        ref_req |-> !req_ready);

endmodule

// File: tb/tb_adram_ctrl.sv
module tb_adram_ctrl;
    localparam int CLK_PS     = 10000;
    localparam int PWRUP_NS   = 2000;
    localparam int REF_INT_NS = 3000;

    function automatic int cyc_up(input int ns);
        return (ns * 1000 + CLK_PS - 1) / CLK_PS;
    endfunction
    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

    localparam int E_RAS    = cyc_up(80);
    localparam int E_RP     = cyc_up(60);
    localparam int E_RCD    = imax(cyc_up(20), cyc_up(10) + 1);
    localparam int E_HOLD   = imax(cyc_up(20), E_RAS - E_RCD);
    localparam int E_RREF   = imax(E_RAS, cyc_up(15));
    localparam int E_PWRUP  = cyc_up(PWRUP_NS);
    localparam int E_INT    = cyc_up(REF_INT_NS);
    localparam int E_RD_LAT = 3 + E_HOLD;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic        req_we = 1'b0;
    logic [21:0] req_addr = '0;
    logic        req_wdata = 1'b0;
    logic        req_ready, rd_valid, rd_data;
    logic        dram_ras_n, dram_cas_n, dram_we_n, dram_din;
    logic [10:0] dram_addr;
    logic        dram_dout = 1'bz;

    always #5 clk = ~clk;

    adram_ctrl #(
        .CLK_PS     (CLK_PS),
        .PWRUP_NS   (PWRUP_NS),
        .REF_INT_NS (REF_INT_NS)
    ) dut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
        .req_we(req_we), .req_addr(req_addr), .req_wdata(req_wdata),
        .rd_valid(rd_valid), .rd_data(rd_data), .dram_ras_n(dram_ras_n),
        .dram_cas_n(dram_cas_n), .dram_we_n(dram_we_n), .dram_addr(dram_addr),
        .dram_din(dram_din), .dram_dout(dram_dout)
    );

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic finish_up();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    // memory model and strobe monitor, sampled mid-cycle
    bit   model [int];
    bit   exp_mem [int];
    logic ras_p = 1'b1, cas_p = 1'b1, we_p = 1'b1;
    int   low_len = 0, high_len = 1000;
    bit   in_ref = 0;
    int   ref_cnt = 0;
    logic [10:0] mon_row, mon_col;
    logic        mon_we;
    int   v_ras_short = 0, v_rp_short = 0, v_rcd = 0, v_cbr = 0;
    int   v_user_len = 0, v_ref_len = 0, v_we_move = 0;

    always @(negedge clk) begin
        if (!rst) begin
            if (!dram_ras_n && ras_p) begin
                if (high_len < E_RP) v_rp_short++;
                if (!dram_cas_n) begin
                    if (cas_p) v_cbr++;
                    in_ref = 1;
                    ref_cnt++;
                end else begin
                    in_ref  = 0;
                    mon_row = dram_addr;
                end
                low_len = 1;
            end else if (!dram_ras_n) begin
                low_len++;
            end
            if (dram_ras_n && !ras_p) begin
                if (low_len < E_RAS) v_ras_short++;
                if (in_ref && low_len != E_RREF) v_ref_len++;
                if (!in_ref && low_len != E_RCD + E_HOLD) v_user_len++;
                high_len = 1;
            end else if (dram_ras_n) begin
                high_len++;
            end
            if (!dram_cas_n && cas_p && !dram_ras_n && !in_ref) begin
                mon_col = dram_addr;
                mon_we  = dram_we_n;
                if (low_len - 1 != E_RCD) v_rcd++;
                if (dram_we_n != we_p) v_we_move++;
                if (!dram_we_n)
                    model[int'({mon_row, dram_addr})] = dram_din;
                else
                    dram_dout <= model.exists(int'({mon_row, dram_addr})) ?
                                 model[int'({mon_row, dram_addr})] : 1'bx;
            end
            if (dram_cas_n && !cas_p) dram_dout <= 1'bz;
            ras_p = dram_ras_n;
            cas_p = dram_cas_n;
            we_p  = dram_we_n;
        end
    end

    task automatic issue(input bit we, input logic [21:0] a, input bit d);
        @(negedge clk);
        req_valid = 1'b1; req_we = we; req_addr = a; req_wdata = d;
        while (!req_ready) @(negedge clk);
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic do_write(input logic [21:0] a, input bit d);
        int pulses = 0;
        issue(1'b1, a, d);
        for (int i = 0; i < E_RD_LAT + 2; i++) begin
            if (rd_valid) pulses++;
            @(negedge clk);
        end
        exp_mem[int'(a)] = d;
        chk(pulses == 0, "R6 no return on write", pulses, 0);
        chk(mon_row == a[21:11], "R1 row half (write)", int'(mon_row), int'(a[21:11]));
        chk(mon_col == a[10:0], "R1 column half (write)", int'(mon_col), int'(a[10:0]));
        chk(mon_we == 1'b0, "R5 early write enable", int'(mon_we), 0);
        chk(model.exists(int'(a)) && model[int'(a)] == d, "R5 data at column fall",
            model.exists(int'(a)) ? int'(model[int'(a)]) : -1, int'(d));
    endtask

    task automatic do_read(input logic [21:0] a);
        int lat = 0;
        issue(1'b0, a, 1'b0);
        while (!rd_valid && lat < 60) begin
            @(negedge clk);
            lat++;
        end
        chk(lat == E_RD_LAT, "R6 read latency", lat, E_RD_LAT);
        chk(rd_data === exp_mem[int'(a)], "R6 read data", int'(rd_data), int'(exp_mem[int'(a)]));
        @(negedge clk);
        chk(rd_valid == 1'b0, "R6 single-cycle pulse", int'(rd_valid), 0);
        chk(mon_row == a[21:11], "R1 row half (read)", int'(mon_row), int'(a[21:11]));
        chk(mon_col == a[10:0], "R1 column half (read)", int'(mon_col), int'(a[10:0]));
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual %0d expected %0d", cyc, 150000);
        finish_up();
    end

    initial begin
        logic [21:0] addrs [46];
        int wait_cyc;
        int r0, t0, got;

        repeat (4) @(posedge clk);
        @(negedge clk);
        // R10: reset state
        chk(dram_ras_n && dram_cas_n && dram_we_n, "R10 strobes high in reset",
            int'({dram_ras_n, dram_cas_n, dram_we_n}), 7);
        chk(!rd_valid && !req_ready, "R10 outputs idle in reset",
            int'({rd_valid, req_ready}), 0);
        rst = 1'b0;

        // R2: start-up gate
        wait_cyc = 0;
        while (!req_ready && wait_cyc < 5000) begin
            @(negedge clk);
            wait_cyc++;
        end
        chk(wait_cyc >= E_PWRUP, "R2 pause before first accept", wait_cyc, E_PWRUP);
        chk(ref_cnt == 8, "R2 start-up refresh count", ref_cnt, 8);

        // walking ones and walking zeros over the 22 address bits, plus the corners
        for (int i = 0; i < 22; i++) begin
            addrs[i]      = 22'(1) << i;
            addrs[22 + i] = ~(22'(1) << i);
        end
        addrs[44] = '0;
        addrs[45] = '1;
        for (int i = 0; i < 46; i++) do_write(addrs[i], (^addrs[i]) ^ addrs[i][3]);
        do_write(addrs[5], !((^addrs[5]) ^ addrs[5][3]));   // overwrite
        for (int i = 0; i < 46; i++) do_read(addrs[i]);

        // R4: refresh rate with the host idle
        r0 = ref_cnt;
        repeat (10 * E_INT) @(negedge clk);
        got = ref_cnt - r0;
        chk(got >= 9 && got <= 11, "R4 refreshes in ten idle intervals", got, 10);

        // R9: refreshes keep their rate under back-to-back reads
        r0 = ref_cnt;
        t0 = cyc;
        for (int k = 0; k < 80; k++) do_read(addrs[(k * 7) % 46]);
        got = ref_cnt - r0;
        chk(got >= (cyc - t0) / E_INT - 1, "R9 refreshes under traffic", got, (cyc - t0) / E_INT);
        chk(v_user_len == 0, "R9 user cycles not cut short", v_user_len, 0);

        // R3, R5, R7, R8: strobe timing seen by the monitor across the run
        chk(v_cbr == 0, "R3 column strobe leads in refresh", v_cbr, 0);
        chk(v_ref_len == 0, "R3 refresh strobe overlap length", v_ref_len, 0);
        chk(v_we_move == 0, "R5 write enable stable at column fall", v_we_move, 0);
        chk(v_ras_short == 0, "R7 row strobe low width", v_ras_short, 0);
        chk(v_rp_short == 0, "R7 precharge width", v_rp_short, 0);
        chk(v_rcd == 0, "R8 row-to-column delay", v_rcd, 0);

        finish_up();
    end

endmodule